// File: doc/BRIEF.md
# Processing Element Run-State Controller

This block is the control state machine of one processing element in a linear array. A host broadcasts four commands (reset, pause, load and run), and the controller turns them into a single phase for the element. In the load phase the controller copies a program from the shared memory on the element's left into the element's local control memory. The copy starts only once the left memory's ready flag is set. In the run phase the controller enables instruction fetch and execution, and it clears the program counter on entry.

The left memory is read through a per-element address register. A reset command returns that register to zero. The register then steps by one on every read, and it keeps its value from one load to the next. The first word read in a load is a header that gives the program length. That many words follow, and they are written to control-memory addresses 0, 1, 2 and so on. A run command that arrives while a load is in progress is held back. It takes effect in the cycle the load completes.

Top module: `pe_run_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the controller enters phase RESET. `ctrl_state` encodes RESET=00, PAUSE=01, LOAD=10 and RUN=11. In RESET, `run_en`, `lm_rd_en` and `cm_wr_en` are all low.
- R2: Commands sampled in the same cycle are resolved by priority: reset first, then pause, then load, then run. An accepted reset command moves the controller to RESET and clears the left-memory address register to zero. It also raises `mem_init` for exactly the next cycle.
- R3: A pause command moves the controller to PAUSE with `run_en` low. If the pause arrives during a load, the load is abandoned: no further control-memory writes occur and no `load_done` pulse follows.
- R4: In LOAD, no left-memory read is issued until `lflag_set` is high.
- R5: A load first reads a header word at the address register. Bits [CW:0] of the header give the word count, and the upper bits are ignored. The load then reads that many words at the following consecutive addresses and writes them, in the same order, to control-memory addresses 0 upward with unchanged data.
- R6: A header count larger than 2**CW is treated as 2**CW. A count of zero ends the load with no writes.
- R7: When a load completes, `load_done` is high for exactly one cycle, which is the first cycle after the final write. In that cycle the phase is RUN if a run is pending, and PAUSE otherwise.
- R8: A run command received during LOAD, or in the same cycle as the load command, leaves the controller in LOAD with `run_en` low until the load completes. The controller then enters RUN in the same cycle that `load_done` is high.
- R9: On every entry into RUN, `run_en` goes high and `pc_clear` is high for exactly the first RUN cycle.
- R10: Without an intervening reset command, a second load continues from the address that follows the last word read by the previous load.
- R11: A load command during LOAD has no effect: the load in progress neither restarts nor repeats. A run command during RUN produces no new `pc_clear`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_reset | input | 1 | Host reset command, sampled each cycle |
| cmd_pause | input | 1 | Host pause command |
| cmd_load | input | 1 | Host load command |
| cmd_run | input | 1 | Host run command |
| lflag_set | input | 1 | Ready flag of the left shared memory |
| lm_rd_en | output | 1 | Left-memory read strobe (data returns the next cycle) |
| lm_rd_addr | output | AW | Left-memory read address (address register value) |
| lm_rd_data | input | DW | Left-memory read data, one cycle after the strobe |
| cm_wr_en | output | 1 | Control-memory write strobe |
| cm_wr_addr | output | CW | Control-memory write address |
| cm_wr_data | output | DW | Control-memory write data |
| mem_init | output | 1 | One-cycle pulse after a reset command is accepted |
| load_done | output | 1 | One-cycle pulse when a load completes |
| run_en | output | 1 | Instruction fetch and execute enable |
| pc_clear | output | 1 | Program counter clear, first RUN cycle |
| ctrl_state | output | 2 | Current phase (00 RESET, 01 PAUSE, 10 LOAD, 11 RUN) |

## Verification
A wrong phase register shows up on `ctrl_state` and `run_en` one cycle after the command that caused it. A lost run-pending bit shows up as PAUSE where RUN was expected, in the cycle of `load_done`. A corrupt address register or count register shows up as wrong words, too few writes or too many writes on the control-memory port during that same load. A stale address register shows up as a wrong header on the next load after a reset command. The stimulus therefore compares every written word and every write count per load, and it checks the phase in the exact cycle each transition must happen.

// File: rtl/pectl_pkg.sv
// Shared types for the processing-element run-state controller.
// Assumes: phase encoding is visible at the top ports and must stay fixed.
package pectl_pkg;

    // Element phase; the encoding is part of the port contract.
    typedef enum logic [1:0] {
        PH_RESET = 2'b00,
        PH_PAUSE = 2'b01,
        PH_LOAD  = 2'b10,
        PH_RUN   = 2'b11
    } phase_e;

    // Sub-steps of the program copy.
    typedef enum logic [1:0] {
        LS_WAIT = 2'b00,   // waiting for the left-memory flag
        LS_HDR  = 2'b01,   // header word on the read bus
        LS_XFER = 2'b10    // streaming program words
    } ldsub_e;

    // Arbitrated command grants; run may accompany load.
    typedef struct packed {
        logic take_reset;
        logic take_pause;
        logic take_load;
        logic take_run;
    } cmd_t;

endpackage

// File: rtl/pectl_cmd_arb.sv
// Command arbiter.
// Resolves the four host command inputs into grants using a fixed priority:
// reset, then pause, then load, then run. Reset and pause each exclude
// everything below them. Run is granted alongside load, so that a run
// issued together with a load can be held pending by the phase machine.
// Assumes: commands are sampled once per clock; there is no internal state.
module pectl_cmd_arb
    import pectl_pkg::*;
(
    input  logic cmd_reset,
    input  logic cmd_pause,
    input  logic cmd_load,
    input  logic cmd_run,
    output cmd_t grant
);

    localparam int NLVL = 3;          // exclusive priority levels

    logic [NLVL-1:0] req;
    logic [NLVL-1:0] blocked;
    logic [NLVL-1:0] won;

    assign req = {cmd_load, cmd_pause, cmd_reset};

    // Priority chain: each level is blocked by any request above it.
    assign blocked[0] = 1'b0;
    genvar g;
    generate
        for (g = 1; g < NLVL; g++) begin : g_chain
            assign blocked[g] = blocked[g-1] | req[g-1];
        end
        for (g = 0; g < NLVL; g++) begin : g_win
            assign won[g] = req[g] & ~blocked[g];
        end
    endgenerate

    // Map grants into the command structure; run only loses to reset/pause.
    always_comb begin
        grant.take_reset = won[0];
        grant.take_pause = won[1];
        grant.take_load  = won[2];
        grant.take_run   = cmd_run & ~cmd_reset & ~cmd_pause;
    end

endmodule

// File: rtl/pectl_phase_fsm.sv
// Phase state machine.
// Holds the element phase and the run-pending bit, and produces the
// registered pulses seen by the rest of the element (pc_clear, load_done,
// mem_init). It tells the load sequencer whether a load is live and
// whether it is being cut short in the current cycle.
// Assumes: ld_last is only meaningful while the phase is LOAD.
module pectl_phase_fsm
    import pectl_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  cmd_t   grant,
    input  logic   ld_last,
    output phase_e phase,
    output logic   ld_go,
    output logic   ld_abort,
    output logic   ar_clear,
    output logic   run_en,
    output logic   pc_clear,
    output logic   load_done,
    output logic   mem_init
);

    phase_e phase_nxt;
    logic   run_pnd;
    logic   run_pnd_nxt;
    logic   ld_fin;

    assign ld_abort = grant.take_reset | grant.take_pause;
    assign ld_go    = (phase == PH_LOAD);
    assign ar_clear = grant.take_reset;
    assign ld_fin   = ld_go & ld_last & ~ld_abort;
    assign run_en   = (phase == PH_RUN);

    // Next phase and pending-run decision.
    always_comb begin
        phase_nxt   = phase;
        run_pnd_nxt = run_pnd;
        if (grant.take_reset) begin
            phase_nxt   = PH_RESET;
            run_pnd_nxt = 1'b0;
        end else if (grant.take_pause) begin
            phase_nxt   = PH_PAUSE;
            run_pnd_nxt = 1'b0;
        end else begin
            case (phase)
                PH_LOAD: begin
                    if (ld_fin) begin
                        phase_nxt   = (run_pnd | grant.take_run) ? PH_RUN : PH_PAUSE;
                        run_pnd_nxt = 1'b0;
                    end else if (grant.take_run) begin
                        run_pnd_nxt = 1'b1;
                    end
                end
                PH_RUN: begin
                    if (grant.take_load) begin
                        phase_nxt   = PH_LOAD;
                        run_pnd_nxt = grant.take_run;
                    end
                end
                default: begin
                    if (grant.take_load) begin
                        phase_nxt   = PH_LOAD;
                        run_pnd_nxt = grant.take_run;
                    end else if (grant.take_run) begin
                        phase_nxt   = PH_RUN;
                    end
                end
            endcase
        end
    end

    // Phase register and registered pulse outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_RESET;
            run_pnd   <= 1'b0;
            pc_clear  <= 1'b0;
            load_done <= 1'b0;
            mem_init  <= 1'b0;
        end else begin
            phase     <= phase_nxt;
            run_pnd   <= run_pnd_nxt;
            pc_clear  <= (phase_nxt == PH_RUN) && (phase != PH_RUN);
            load_done <= ld_fin;
            mem_init  <= grant.take_reset;
        end
    end

endmodule

// File: rtl/pectl_load_seq.sv
// Program load sequencer.
// While the load is live: waits for the left-memory flag, reads a header
// word at the address register, takes its count field (saturated to the
// control-memory depth), then streams that many words from consecutive
// addresses into control memory starting at address zero. Reads and writes
// overlap, so one word moves per cycle after a one-cycle header bubble.
// Assumes: the left memory returns read data one cycle after lm_rd_en and
// holds it until the next read.
module pectl_load_seq
    import pectl_pkg::*;
#(
    parameter int AW = 8,
    parameter int CW = 5,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_go,
    input  logic          ld_abort,
    input  logic          ar_clear,
    input  logic          flag,
    input  logic [DW-1:0] rd_data,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    output logic          wr_en,
    output logic [CW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          ld_last,
    output ldsub_e        sub_o
);

    localparam int          CNTW   = CW + 1;
    localparam int          DEPTH  = 1 << CW;
    localparam logic [CW:0] DEPTHV = DEPTH[CW:0];

    ldsub_e          sub;
    logic [AW-1:0]   ar0;
    logic [CNTW-1:0] rd_left;
    logic [CNTW-1:0] wr_left;
    logic [CW-1:0]   wr_ptr;
    logic            rd_pend;
    logic            live;
    logic [CNTW-1:0] hdr_raw;
    logic [CNTW-1:0] hdr_cnt;

    assign live    = ld_go & ~ld_abort;
    assign hdr_raw = rd_data[CW:0];
    assign sub_o   = sub;

    // Header count with saturation at the control-memory depth.
    always_comb begin
        hdr_cnt = (hdr_raw > DEPTHV) ? DEPTHV : hdr_raw;
    end

    // Read/write strobes and the completion condition.
    always_comb begin
        rd_en   = live & (((sub == LS_WAIT) & flag) |
                          ((sub == LS_XFER) & (rd_left != '0)));
        rd_addr = ar0;
        wr_en   = live & (sub == LS_XFER) & rd_pend;
        wr_addr = wr_ptr;
        wr_data = rd_data;
        ld_last = live & (((sub == LS_HDR) & (hdr_cnt == '0)) |
                          (wr_en & (wr_left == CNTW'(1))));
    end

    // Address register zero: cleared by a reset command, steps on each read.
    always_ff @(posedge clk) begin
        if (!rst_n || ar_clear) begin
            ar0 <= '0;
        end else if (rd_en) begin
            ar0 <= ar0 + AW'(1);
        end
    end

    // Load sub-state, counters and the read-pending marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sub     <= LS_WAIT;
            rd_left <= '0;
            wr_left <= '0;
            wr_ptr  <= '0;
            rd_pend <= 1'b0;
        end else if (!live || ld_last) begin
            sub     <= LS_WAIT;
            rd_pend <= 1'b0;
        end else begin
            rd_pend <= rd_en & (sub == LS_XFER);
            case (sub)
                LS_WAIT: begin
                    if (flag) sub <= LS_HDR;
                end
                LS_HDR: begin
                    sub     <= LS_XFER;
                    rd_left <= hdr_cnt;
                    wr_left <= hdr_cnt;
                    wr_ptr  <= '0;
                end
                default: begin
                    if (rd_en) rd_left <= rd_left - CNTW'(1);
                    if (wr_en) begin
                        wr_left <= wr_left - CNTW'(1);
                        wr_ptr  <= wr_ptr + CW'(1);
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/pe_run_ctrl.sv
// Processing element run-state controller (top).
// Joins the command arbiter, the phase machine and the load sequencer.
// Assumes: host commands are synchronous to clk; the left memory has a
// one-cycle read latency; control memory accepts one write per cycle.
module pe_run_ctrl
    import pectl_pkg::*;
#(
    parameter int AW = 8,
    parameter int CW = 5,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_reset,
    input  logic          cmd_pause,
    input  logic          cmd_load,
    input  logic          cmd_run,
    input  logic          lflag_set,
    output logic          lm_rd_en,
    output logic [AW-1:0] lm_rd_addr,
    input  logic [DW-1:0] lm_rd_data,
    output logic          cm_wr_en,
    output logic [CW-1:0] cm_wr_addr,
    output logic [DW-1:0] cm_wr_data,
    output logic          mem_init,
    output logic          load_done,
    output logic          run_en,
    output logic          pc_clear,
    output logic [1:0]    ctrl_state
);

    cmd_t   grant;
    phase_e phase;
    logic   ld_go;
    logic   ld_abort;
    logic   ar_clear;
    logic   ld_last;
    ldsub_e ld_sub;

    pectl_cmd_arb u_arb (
        .cmd_reset (cmd_reset),
        .cmd_pause (cmd_pause),
        .cmd_load  (cmd_load),
        .cmd_run   (cmd_run),
        .grant     (grant)
    );

    pectl_phase_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .grant     (grant),
        .ld_last   (ld_last),
        .phase     (phase),
        .ld_go     (ld_go),
        .ld_abort  (ld_abort),
        .ar_clear  (ar_clear),
        .run_en    (run_en),
        .pc_clear  (pc_clear),
        .load_done (load_done),
        .mem_init  (mem_init)
    );

    pectl_load_seq #(
        .AW (AW),
        .CW (CW),
        .DW (DW)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_go    (ld_go),
        .ld_abort (ld_abort),
        .ar_clear (ar_clear),
        .flag     (lflag_set),
        .rd_data  (lm_rd_data),
        .rd_en    (lm_rd_en),
        .rd_addr  (lm_rd_addr),
        .wr_en    (cm_wr_en),
        .wr_addr  (cm_wr_addr),
        .wr_data  (cm_wr_data),
        .ld_last  (ld_last),
        .sub_o    (ld_sub)
    );

    assign ctrl_state = phase;

endmodule

// File: rtl/pe_run_ctrl_chk.sv
// Property checker for pe_run_ctrl, attached by bind.
// Assumes: phase encoding 00 RESET, 01 PAUSE, 10 LOAD, 11 RUN.
module pe_run_ctrl_chk
    import pectl_pkg::*;
#(
    parameter int CW = 5
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] ctrl_state,
    input logic       run_en,
    input logic       pc_clear,
    input logic       load_done,
    input logic       mem_init,
    input logic       cm_wr_en,
    input logic       lm_rd_en,
    input logic       lflag_set,
    input ldsub_e     ld_sub
);

    localparam int DEPTH = 1 << CW;

    logic            rst_q;
    logic [CW+1:0]   wcnt;

    // Remembers that reset was applied at the previous edge.
    always_ff @(posedge clk) rst_q <= !rst_n;

    // Counts control-memory writes inside one load.
    always_ff @(posedge clk) begin
        if (!rst_n || ctrl_state != 2'b10) wcnt <= '0;
        else if (cm_wr_en)                 wcnt <= wcnt + 1'b1;
    end

    // R1
    reset_phase_chk: assert property (@(posedge clk)
        rst_q |-> (ctrl_state == 2'b00 && !run_en && !cm_wr_en));

    // R2
    init_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_init |-> ctrl_state == 2'b00);

    // R3
    pause_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_state == 2'b01) |-> (!run_en && !cm_wr_en && !lm_rd_en));

    // R4
    flag_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lm_rd_en && ld_sub == LS_WAIT) |-> lflag_set);

    // R6
    write_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cm_wr_en |-> (wcnt < (CW+2)'(DEPTH)));

    // R7
    done_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |-> ($past(ctrl_state) == 2'b10 && ctrl_state != 2'b10));

    // R8
    run_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(run_en) && $past(ctrl_state) == 2'b10) |-> load_done);

    // R9
    pc_on_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_en) |-> pc_clear);

    // R9
    pc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_clear |=> !pc_clear);

endmodule

bind pe_run_ctrl pe_run_ctrl_chk #(.CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_state (ctrl_state),
    .run_en     (run_en),
    .pc_clear   (pc_clear),
    .load_done  (load_done),
    .mem_init   (mem_init),
    .cm_wr_en   (cm_wr_en),
    .lm_rd_en   (lm_rd_en),
    .lflag_set  (lflag_set),
    .ld_sub     (ld_sub)
);

// File: tb/tb_pe_run_ctrl.sv
// Self-checking bench for pe_run_ctrl: a vector table of load scenarios,
// then directed tests for reset, priority, abort and hold cases.
module tb_pe_run_ctrl;

    localparam int AW    = 8;
    localparam int CW    = 5;
    localparam int DW    = 32;
    localparam int DEPTH = 1 << CW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_reset = 1'b0, cmd_pause = 1'b0, cmd_load = 1'b0, cmd_run = 1'b0;
    logic          lflag_set = 1'b0;
    logic          lm_rd_en;
    logic [AW-1:0] lm_rd_addr;
    logic [DW-1:0] lm_rd_data = '0;
    logic          cm_wr_en;
    logic [CW-1:0] cm_wr_addr;
    logic [DW-1:0] cm_wr_data;
    logic          mem_init, load_done, run_en, pc_clear;
    logic [1:0]    ctrl_state;

    logic [DW-1:0] lmem [0:(1<<AW)-1];
    logic [DW-1:0] cmem [0:DEPTH-1];

    int nchk = 0, nfail = 0;
    int wr_cnt = 0, done_cnt = 0, pcc_cnt = 0, rd_cnt = 0, mi_cnt = 0;

    always #4 clk = ~clk;   // 125 MHz

    pe_run_ctrl #(.AW(AW), .CW(CW), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_reset(cmd_reset), .cmd_pause(cmd_pause), .cmd_load(cmd_load), .cmd_run(cmd_run),
        .lflag_set(lflag_set),
        .lm_rd_en(lm_rd_en), .lm_rd_addr(lm_rd_addr), .lm_rd_data(lm_rd_data),
        .cm_wr_en(cm_wr_en), .cm_wr_addr(cm_wr_addr), .cm_wr_data(cm_wr_data),
        .mem_init(mem_init), .load_done(load_done), .run_en(run_en),
        .pc_clear(pc_clear), .ctrl_state(ctrl_state)
    );

    // Left memory model with one-cycle read latency.
    always @(posedge clk) if (lm_rd_en) lm_rd_data <= lmem[lm_rd_addr];

    // Monitor: records writes and pulses mid-cycle.
    always @(negedge clk) begin
        if (cm_wr_en) begin cmem[cm_wr_addr] = cm_wr_data; wr_cnt++; end
        if (load_done) done_cnt++;
        if (pc_clear)  pcc_cnt++;
        if (lm_rd_en)  rd_cnt++;
        if (mem_init)  mi_cnt++;
    end

    typedef struct packed {
        logic [7:0] hdr;
        logic [3:0] dly;
        logic       with_run;
        logic [1:0] exp_ph;
        logic [7:0] exp_wr;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{8'd3,  4'd0, 1'b0, 2'b01, 8'd3},
        '{8'd5,  4'd4, 1'b1, 2'b11, 8'd5},
        '{8'd0,  4'd0, 1'b0, 2'b01, 8'd0},
        '{8'd40, 4'd2, 1'b1, 2'b11, 8'd32},
        '{8'd32, 4'd0, 1'b0, 2'b01, 8'd32}
    };

    function automatic logic [DW-1:0] pat(input int v, input int k);
        return {8'(v), 8'h5A, 16'(k)};
    endfunction

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cmd(input bit r, input bit p, input bit l, input bit u);
        cmd_reset = r; cmd_pause = p; cmd_load = l; cmd_run = u;
        step();
        cmd_reset = 0; cmd_pause = 0; cmd_load = 0; cmd_run = 0;
    endtask

    task automatic wait_done(input int d0);
        int n = 0;
        while (done_cnt == d0 && n < 200) begin step(); n++; end
    endtask

    int w0, d0, p0, r0, m0, bad;

    initial begin
        repeat (3) step();
        // R1: reset state
        chk(ctrl_state == 2'b00, "R1 state", ctrl_state, 0);
        chk(!run_en && !lm_rd_en && !cm_wr_en, "R1 outputs idle", run_en, 0);
        rst_n = 1'b1;
        step();

        // Vector table: load scenarios
        for (int v = 0; v < 5; v++) begin
            m0 = mi_cnt;
            cmd(1, 0, 0, 0);
            step();
            chk(mi_cnt == m0 + 1, "R2 mem_init pulse", mi_cnt - m0, 1);
            lflag_set = 1'b0;
            lmem[0] = 32'hF0F0_0000 | 32'(VECS[v].hdr);
            for (int k = 1; k <= 40; k++) lmem[k] = pat(v, k);
            w0 = wr_cnt; d0 = done_cnt; p0 = pcc_cnt; r0 = rd_cnt;
            cmd(0, 0, 1, 0);
            if (VECS[v].with_run) begin
                cmd(0, 0, 0, 1);
                // R8: run held while load in progress
                chk(ctrl_state == 2'b10 && !run_en, "R8 run held", ctrl_state, 2);
            end
            repeat (int'(VECS[v].dly)) step();
            if (VECS[v].dly != 0)
                chk(rd_cnt == r0, "R4 no read before flag", rd_cnt - r0, 0);
            lflag_set = 1'b1;
            wait_done(d0);
            chk(done_cnt == d0 + 1, "R7 single done pulse", done_cnt - d0, 1);
            chk(ctrl_state == VECS[v].exp_ph, "R7 phase after load", ctrl_state, VECS[v].exp_ph);
            chk(wr_cnt - w0 == int'(VECS[v].exp_wr), "R6 write count", wr_cnt - w0, VECS[v].exp_wr);
            bad = 0;
            for (int j = 0; j < int'(VECS[v].exp_wr); j++)
                if (cmem[j] !== pat(v, j + 1)) bad++;
            chk(bad == 0, "R5 word data and order", bad, 0);
            if (VECS[v].with_run) begin
                chk(run_en == 1'b1, "R8 run after load", run_en, 1);
                chk(pcc_cnt == p0 + 1, "R9 pc_clear on entry", pcc_cnt - p0, 1);
            end
        end

        // R3: pause during load aborts it
        cmd(1, 0, 0, 0);
        lmem[0] = 32'd10;
        for (int k = 1; k <= 10; k++) lmem[k] = pat(9, k);
        lflag_set = 1'b1;
        w0 = wr_cnt; d0 = done_cnt;
        cmd(0, 0, 1, 0);
        repeat (4) step();
        cmd(0, 1, 0, 0);
        repeat (2) step();
        r0 = wr_cnt;
        repeat (20) step();
        chk(wr_cnt == r0 && (r0 - w0) < 10, "R3 no writes after pause", wr_cnt - w0, r0 - w0);
        chk(done_cnt == d0, "R3 no done after abort", done_cnt - d0, 0);
        chk(ctrl_state == 2'b01 && !run_en, "R3 paused", ctrl_state, 1);

        // R9 / R11: run from pause, then repeated run
        p0 = pcc_cnt;
        cmd(0, 0, 0, 1);
        step();
        chk(run_en && ctrl_state == 2'b11, "R9 run entry", ctrl_state, 3);
        cmd(0, 0, 0, 1);
        step();
        chk(pcc_cnt == p0 + 1, "R11 no second pc_clear", pcc_cnt - p0, 1);

        // R2: all commands at once from RUN, reset wins
        m0 = mi_cnt;
        cmd(1, 1, 1, 1);
        step();
        chk(ctrl_state == 2'b00 && mi_cnt == m0 + 1, "R2 reset priority", ctrl_state, 0);
        cmd(0, 0, 0, 1);
        cmd(0, 1, 1, 1);
        chk(ctrl_state == 2'b01, "R2 pause over load and run", ctrl_state, 1);

        // R8: load and run in the same cycle (address register still zero)
        lmem[0] = 32'd1; lmem[1] = pat(7, 1);
        d0 = done_cnt;
        cmd(0, 0, 1, 1);
        chk(ctrl_state == 2'b10 && !run_en, "R8 simultaneous load held", ctrl_state, 2);
        wait_done(d0);
        chk(ctrl_state == 2'b11 && cmem[0] == pat(7, 1), "R8 simultaneous run after load", ctrl_state, 3);

        // R10: address register persists across loads
        cmd(1, 0, 0, 0);
        lmem[0] = 32'd2; lmem[1] = pat(5, 1); lmem[2] = pat(5, 2);
        lmem[3] = 32'd1; lmem[4] = pat(5, 4);
        d0 = done_cnt;
        cmd(0, 0, 1, 0);
        wait_done(d0);
        w0 = wr_cnt; d0 = done_cnt;
        cmd(0, 0, 1, 0);
        wait_done(d0);
        chk(wr_cnt - w0 == 1 && cmem[0] == pat(5, 4), "R10 continue address", wr_cnt - w0, 1);

        // R11: load during load is ignored
        cmd(1, 0, 0, 0);
        lmem[0] = 32'd6;
        for (int k = 1; k <= 6; k++) lmem[k] = pat(3, k);
        w0 = wr_cnt; d0 = done_cnt;
        cmd(0, 0, 1, 0);
        repeat (3) step();
        cmd(0, 0, 1, 0);
        wait_done(d0);
        repeat (5) step();
        chk(wr_cnt - w0 == 6 && done_cnt == d0 + 1, "R11 load not restarted", wr_cnt - w0, 6);
        chk(cmem[5] == pat(3, 6), "R11 last word intact", cmem[5], pat(3, 6));

        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule